// File: doc/BRIEF.md
# Chip-Selected Serial Configuration Target

This block is a two-wire serial management target (SMBus/I2C style) that gives a host byte-wide access to a small set of configuration registers. It runs entirely from a fast system clock. The clock and data lines are synchronised and sampled on that clock, and the data line is pulled low through an output-enable that drives an open-drain pad. An active-high chip-select gates the whole port. Several targets that share one bus address can therefore be told apart by their selects.

A host writes a register with one transaction: the device address with the write bit, a register pointer, then one data byte. A host reads a register by writing the pointer, issuing a repeated START, sending the device address with the read bit, and clocking in one byte before its NACK and STOP. The 7-bit device address is held in register 0x00 and can be changed at run time. Register 0x01 holds a self-clearing software reset. Register 0x21 is a control byte whose lower seven bits are write-protected field by field. Register 0x22 holds the unlock bits that open those fields. Register 0x0F is a read-only identity byte.

Top module: `cfg_smb_target`

## Requirements
- R1: After reset the data output-enable is low, the control byte (register 0x21, also on `ctrl_o`) is 0x25, the unlock register 0x22 is 0x00 and the device address is 0x58, so the write address byte is 0xB0.
- R2: A write of START, address byte with bit 0 = 0, pointer, data and STOP gets a slave ACK (line pulled to 0) in the ninth clock of each of the three bytes. The data byte lands in the register named by the pointer.
- R3: A read (pointer write, repeated START, address byte with bit 0 = 1) gets ACKs on all three host bytes. The slave then drives the addressed register MSB first, one bit per SCL low phase, and releases the line for the host's NACK.
- R4: An address byte whose bits 7:1 differ from the programmed address gets no ACK, and the rest of that transaction is ignored (no ACK, no register change).
- R5: While the chip-select is low, all bus activity is ignored: the output-enable stays low and no register is written.
- R6: Register 0x00 holds the device address in bits 7:1 and reads back with bit 0 = 0. A write to it takes effect from the next transaction: the old address is then refused and the new one acknowledged.
- R7: Writing a 1 to bit 0 of register 0x01 returns registers 0x21 and 0x22 to their defaults and leaves the programmed device address unchanged. Register 0x01 always reads 0x00.
- R8: A write to register 0x21 changes bit 7 unconditionally. It changes bit 6, 5, 4, 3 and 2 only when unlock bit 6, 5, 4, 2 and 1 of register 0x22 is set, and it changes bits 1:0 only when unlock bit 0 is set. Locked bits keep their value. Register 0x22 is fully writable.
- R9: Register 0x0F reads 0xA5 and ignores writes, which are still acknowledged. Every other register address not named above reads 0x00.
- R10: A STOP condition while selected releases the data line in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Active-high chip-select for the serial port |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| ctrl_o | output | 8 | Current value of control register 0x21 |

## Verification
The bound checker checks on every cycle that deselection releases the line and blocks writes, that STOP releases the line, and that a software reset never moves the device address. It also checks that a control write only changes bits opened by the unlock register and that the control byte is otherwise stable. Only the bench's transactions can show bit-level protocol conformance: ACK placement, MSB-first read data across a repeated START, address matching and re-addressing, and the read-back values of read-only and unimplemented registers. A reference model of the register file tracks random mixes of selects, addresses and pointers against these scenarios.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int DEVA_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] RA_DEVADDR = 8'h00;
    localparam logic [BYTE_W-1:0] RA_SWRST   = 8'h01;
    localparam logic [BYTE_W-1:0] RA_IDENT   = 8'h0F;
    localparam logic [BYTE_W-1:0] RA_CTRL    = 8'h21;
    localparam logic [BYTE_W-1:0] RA_UNLOCK  = 8'h22;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK, ST_WDAT, ST_WDAT_ACK, ST_RDAT
    } link_st_e;

    // Map unlock bits to the control bits they open; bit 7 is never locked.
    function automatic logic [BYTE_W-1:0] unlock_mask(input logic [BYTE_W-1:0] ov);
        return {1'b1, ov[6], ov[5], ov[4], ov[2], ov[1], ov[0], ov[0]};
    endfunction
endpackage

// File: rtl/smb_pin_sync.sv
module smb_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    assign scl_s = q.scl_ff[STAGES-1];
    assign sda_s = q.sda_ff[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_evt = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_evt  = scl_s & q.scl_p & ~q.sda_p & sda_s;
endmodule

// File: rtl/smb_link_fsm.sv
module smb_link_fsm
    import smb_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [DEVA_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    typedef struct packed {
        link_st_e          st;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              full;
        logic              rw;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              wr;
    } link_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    link_t q, d;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (!cs_i) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else if (start_evt) begin
            d.st   = ST_DEV;
            d.cnt  = '0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else if (stop_evt) begin
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.full = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_REG, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh   = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt  = q.cnt + 1'b1;
                        d.full = (q.cnt == LAST);
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        if (q.st == ST_DEV) begin
                            if (q.sh[BYTE_W-1:1] == dev_addr) begin
                                d.rw = q.sh[0];
                                d.oe = 1'b1;
                                d.st = ST_DEV_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_REG) begin
                            d.ptr = q.sh;
                            d.oe  = 1'b1;
                            d.st  = ST_REG_ACK;
                        end else begin
                            d.wr = 1'b1;
                            d.oe = 1'b1;
                            d.st = ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rw) begin
                        d.st = ST_RDAT;
                        d.sh = rd_data;
                        d.oe = ~rd_data[BYTE_W-1];
                    end else begin
                        d.st = ST_REG;
                        d.oe = 1'b0;
                    end
                end
                ST_REG_ACK: if (scl_fall) begin
                    d.st  = ST_WDAT;
                    d.oe  = 1'b0;
                    d.cnt = '0;
                end
                ST_WDAT_ACK: if (scl_fall) begin
                    d.st = ST_IDLE;
                    d.oe = 1'b0;
                end
                ST_RDAT: if (scl_fall) begin
                    if (q.cnt == LAST) begin
                        d.oe = 1'b0;
                        d.st = ST_IDLE;
                    end else begin
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe  = ~q.sh[BYTE_W-2];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign wr_en   = q.wr;
    assign wr_addr = q.ptr;
    assign wr_data = q.sh;
endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
    import smb_tgt_pkg::*;
#(
    parameter logic [DEVA_W-1:0] ADDR_DEFAULT = 7'h58,
    parameter logic [BYTE_W-1:0] CTRL_DEFAULT = 8'h25,
    parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DEVA_W-1:0] dev_addr,
    output logic [BYTE_W-1:0] ctrl,
    output logic [BYTE_W-1:0] unlock
);
    typedef struct packed {
        logic [DEVA_W-1:0] addr;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] ovr;
    } regs_t;

    regs_t             q, d;
    logic [BYTE_W-1:0] mask;

    assign mask = unlock_mask(q.ovr);

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (wr_addr)
                RA_DEVADDR: d.addr = wr_data[BYTE_W-1:1];
                RA_SWRST: if (wr_data[0]) begin
                    d.ctrl = CTRL_DEFAULT;
                    d.ovr  = '0;
                end
                RA_CTRL:   d.ctrl = (q.ctrl & ~mask) | (wr_data & mask);
                RA_UNLOCK: d.ovr  = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{addr: ADDR_DEFAULT, ctrl: CTRL_DEFAULT, ovr: '0};
        else        q <= d;
    end

    always_comb begin
        unique case (rd_addr)
            RA_DEVADDR: rd_data = {q.addr, 1'b0};
            RA_IDENT:   rd_data = ID_VALUE;
            RA_CTRL:    rd_data = q.ctrl;
            RA_UNLOCK:  rd_data = q.ovr;
            default:    rd_data = '0;
        endcase
    end

    assign dev_addr = q.addr;
    assign ctrl     = q.ctrl;
    assign unlock   = q.ovr;
endmodule

// File: rtl/cfg_smb_target.sv
module cfg_smb_target
    import smb_tgt_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [DEVA_W-1:0] ADDR_DEFAULT = 7'h58,
    parameter logic [BYTE_W-1:0] CTRL_DEFAULT = 8'h25,
    parameter logic [BYTE_W-1:0] ID_VALUE     = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] ctrl_o
);
    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_addr, wr_data, rd_data, unlock;
    logic [DEVA_W-1:0] dev_addr;

    smb_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    smb_link_fsm link_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe_o),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    smb_cfg_regs #(
        .ADDR_DEFAULT(ADDR_DEFAULT), .CTRL_DEFAULT(CTRL_DEFAULT), .ID_VALUE(ID_VALUE)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(wr_addr), .rd_data(rd_data),
        .dev_addr(dev_addr), .ctrl(ctrl_o), .unlock(unlock)
    );
endmodule

// File: rtl/cfg_smb_target_chk.sv
module cfg_smb_target_chk
    import smb_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_i,
    input logic              sda_oe_o,
    input logic              stop_evt,
    input logic              wr_en,
    input logic [BYTE_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic [BYTE_W-1:0] ctrl_o,
    input logic [BYTE_W-1:0] unlock,
    input logic [DEVA_W-1:0] dev_addr
);
    AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !sda_oe_o); // R5

    AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_i |=> !wr_en); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && cs_i) |=> !sda_oe_o); // R10

    AST_SWRST_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_SWRST) |=> $stable(dev_addr)); // R7

    AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CTRL) |=>
            (((ctrl_o ^ $past(ctrl_o)) & ~unlock_mask($past(unlock))) == '0)); // R8

    AST_CTRL_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_o)); // R2

    AST_WRITE_IMPLIES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(cs_i)); // R5

    logic unused_ok;
    assign unused_ok = ^wr_data;
endmodule

bind cfg_smb_target cfg_smb_target_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sda_oe_o(sda_oe_o),
    .stop_evt(stop_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_o(ctrl_o), .unlock(unlock), .dev_addr(dev_addr)
);

// File: tb/cfg_smb_target_tb_top.sv
module cfg_smb_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int WD_CYCLES  = 180000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_i = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe_o;
    logic [7:0] ctrl_o;
    logic       sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [6:0] m_addr = 7'h58;
    logic [7:0] m_ctrl = 8'h25;
    logic [7:0] m_ovr  = 8'h00;

    assign sda_line = sda_m & ~sda_oe_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_smb_target dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .ctrl_o(ctrl_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] ra);
        case (ra)
            8'h00:   return {m_addr, 1'b0};
            8'h0F:   return 8'hA5;
            8'h21:   return m_ctrl;
            8'h22:   return m_ovr;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] ra, input logic [7:0] dv);
        logic [7:0] mk;
        mk = {1'b1, m_ovr[6], m_ovr[5], m_ovr[4], m_ovr[2], m_ovr[1], m_ovr[0], m_ovr[0]};
        case (ra)
            8'h00: m_addr = dv[7:1];
            8'h01: if (dv[0]) begin m_ctrl = 8'h25; m_ovr = 8'h00; end
            8'h21: m_ctrl = (m_ctrl & ~mk) | (dv & mk);
            8'h22: m_ovr = dv;
            default: ;
        endcase
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF/2);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        sda_m = b;    tick(HALF/2);
        scl_m = 1'b1; tick(HALF/2);
        s = sda_line; tick(HALF/2);
        scl_m = 1'b0; tick(HALF/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
        xfer_bit(1'b1, ack);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, s);
            b[i] = s;
        end
        xfer_bit(1'b1, s);
    endtask

    // Write transaction with expected ACKs and model update.
    task automatic do_write(input string req, input logic [7:0] dev, input logic [7:0] ra,
                            input logic [7:0] dv);
        logic a0, a1, a2, ok;
        ok = cs_i && (dev[7:1] == m_addr) && !dev[0];
        bus_start();
        send_byte(dev, a0);
        send_byte(ra, a1);
        send_byte(dv, a2);
        bus_stop();
        check({req, " ack_dev"},  {7'd0, a0}, {7'd0, !ok});
        check({req, " ack_reg"},  {7'd0, a1}, {7'd0, !ok});
        check({req, " ack_data"}, {7'd0, a2}, {7'd0, !ok});
        if (ok) model_write(ra, dv);
        tick(4);
        check({req, " ctrl_o"}, ctrl_o, m_ctrl);
    endtask

    task automatic do_read(input string req, input logic [7:0] dev, input logic [7:0] ra);
        logic a0, a1, a2, ok;
        logic [7:0] rv;
        ok = cs_i && (dev[7:1] == m_addr);
        bus_start();
        send_byte({dev[7:1], 1'b0}, a0);
        send_byte(ra, a1);
        bus_start();
        send_byte({dev[7:1], 1'b1}, a2);
        recv_byte(rv);
        bus_stop();
        check({req, " rd_ack_dev"}, {7'd0, a0}, {7'd0, !ok});
        check({req, " rd_ack_reg"}, {7'd0, a1}, {7'd0, !ok});
        check({req, " rd_ack_rdev"}, {7'd0, a2}, {7'd0, !ok});
        check({req, " rd_data"}, rv, ok ? exp_read(ra) : 8'hFF);
        tick(4);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] ra_list [7];
        void'($urandom(32'h5EED_0124));
        ra_list = '{8'h01, 8'h0F, 8'h21, 8'h22, 8'h05, 8'h40, 8'h21};
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        check("R1 oe", {7'd0, sda_oe_o}, 8'h00);
        check("R1 ctrl", ctrl_o, 8'h25);
        do_read("R1 unlock", 8'hB0, 8'h22);
        do_read("R1 addr", 8'hB0, 8'h00);

        // R2/R3 write and read back
        do_write("R2 unlock_all", 8'hB0, 8'h22, 8'h77);
        do_read("R3 unlock_rb", 8'hB0, 8'h22);
        do_write("R2 ctrl", 8'hB0, 8'h21, 8'hC3);
        do_read("R3 ctrl_rb", 8'hB0, 8'h21);

        // R8 locking
        do_write("R8 lock_all", 8'hB0, 8'h22, 8'h00);
        do_write("R8 locked_write", 8'hB0, 8'h21, 8'h3C);
        check("R8 only_bit7", ctrl_o, 8'h43);
        do_write("R8 unlock_b2", 8'hB0, 8'h22, 8'h04);
        do_write("R8 partial", 8'hB0, 8'h21, 8'hFF);
        check("R8 bit3_open", ctrl_o, 8'hCB);
        do_write("R8 unlock_b0", 8'hB0, 8'h22, 8'h01);
        do_write("R8 low_pair", 8'hB0, 8'h21, 8'h00);
        check("R8 bits10_open", ctrl_o, 8'h48);

        // R4 wrong address
        do_write("R4 wrong_addr", 8'hB2, 8'h21, 8'hFF);
        do_read("R4 wrong_read", 8'h30, 8'h21);

        // R5 chip-select low
        cs_i = 1'b0;
        do_write("R5 deselected", 8'hB0, 8'h21, 8'hFF);
        do_read("R5 deselected_rd", 8'hB0, 8'h22);
        cs_i = 1'b1;
        do_read("R5 after_cs", 8'hB0, 8'h21);

        // R9 read-only and unimplemented
        do_read("R9 ident", 8'hB0, 8'h0F);
        do_write("R9 ident_wr", 8'hB0, 8'h0F, 8'h00);
        do_read("R9 ident_kept", 8'hB0, 8'h0F);
        do_read("R9 unimpl", 8'hB0, 8'h05);
        do_read("R9 swrst_reads0", 8'hB0, 8'h01);

        // R6 address change
        do_write("R6 set_addr", 8'hB0, 8'h00, 8'h6B);
        check("R6 model_addr", {1'b0, m_addr}, 8'h35);
        do_read("R6 old_refused", 8'hB0, 8'h21);
        do_read("R6 new_addr_rb", 8'h6A, 8'h00);

        // R7 software reset keeps address
        do_write("R7 set_unlock", 8'h6A, 8'h22, 8'h55);
        do_write("R7 swrst", 8'h6A, 8'h01, 8'h01);
        check("R7 ctrl_default", ctrl_o, 8'h25);
        do_read("R7 unlock_default", 8'h6A, 8'h22);
        do_read("R7 addr_kept", 8'h6A, 8'h00);
        do_write("R7 no_reset_bit0", 8'h6A, 8'h01, 8'hFE);
        do_write("R6 restore", 8'h6A, 8'h00, 8'hB0);

        // Random mix (R2 R3 R4 R5 R8 R9 R10)
        for (int n = 0; n < 50; n++) begin
            logic [7:0] dev, ra, dv;
            dev = (($urandom % 6) == 0) ? (8'hB0 ^ (8'h01 << (1 + $urandom % 7))) : 8'hB0;
            ra  = ra_list[$urandom % 7];
            dv  = 8'($urandom);
            cs_i = (($urandom % 8) != 0);
            if ($urandom % 2) do_write("R2 R8 rand_wr", dev, ra, dv);
            else              do_read("R3 R9 rand_rd", dev, ra);
            check("R10 idle_after_stop", {7'd0, sda_oe_o}, 8'h00);
        end
        cs_i = 1'b1;
        do_read("R8 final_ctrl", 8'hB0, 8'h21);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule